// File: doc/BRIEF.md
# Multi-Mode Capture Down-Counter Timer

This block is an 8-bit down-counter with a reload latch and one bidirectional event pin. It runs in one of four modes. In square-wave mode it drives the pin and inverts the pin on each underflow. In event-counting mode each selected pin edge counts the timer down by one. In period mode the count is captured on one chosen edge of the pin. In pulse-width mode the count is captured on both edges of the pin. In every mode except event counting, the count source is the system clock divided by 8, 16, 32 or 64.

A capture copies the live count into a capture register and restarts the counter from the reload latch at the same moment. Software then reads the capture register at the timer's own address. Two sticky request flags report the timer events: one for underflow and one for pin-triggered captures. An interrupt controller would consume these flags. The pin input must already be synchronized to the system clock.

Software uses a small register bus with three addresses:

| Address | Register | Write | Read |
|---------|----------|-------|------|
| 0 | timer | sets the reload value | live count, or the capture register in the two measuring modes |
| 1 | control | sets mode, polarity, prescaler and stop | the same fields |
| 2 | flags | clears the request flags | the request flags |
| 3 | none | ignored | 0 |

Top module: `capture_dtimer`

## Requirements
- R1: Reset state.
  - Counter and reload latch are 0xFF.
  - Capture register is 0.
  - The stop bit is 1.
  - Mode is 00, polarity is 0 and prescaler select is 0.
  - Both flags are 0.
  - pin_out is 1 and pin_oe is 1.
- R2: Internal count source.
  - In modes 00, 10 and 11 the counter decrements once every n clocks, with n = 8 << psel.
  - A free-running 6-bit prescaler, cleared by reset, gives a count step on each clock where its value modulo n equals n-1.
  - The prescaler keeps running while the timer is stopped.
- R3: Underflow.
  - A count step taken while the counter is 0 counts as an underflow.
  - On an underflow the counter reloads from the reload latch and flag bit 0 (underflow) is set.
  - The underflow period is therefore reload+1 count steps.
- R4: Square-wave mode (mode 00).
  - pin_oe is 1 only in mode 00.
  - Each underflow inverts pin_out.
  - A write to the control register sets pin_out to the inverse of the written polarity bit: polarity 0 starts high, polarity 1 starts low.
- R5: Event-counting mode (mode 01).
  - Each rising pin edge (polarity 0) or falling pin edge (polarity 1) is one count step.
  - The prescaler is ignored in this mode.
- R6: Period mode (mode 10).
  - The capture edge is the falling edge for polarity 0 and the rising edge for polarity 1.
  - On a capture edge the count is copied into the capture register, the counter loads the reload latch, and flag bit 1 (pin event) is set.
  - The opposite edge has no effect.
  - An edge is acted on at the first clock edge at which the new pin level is sampled.
- R7: Pulse-width mode (mode 11). Both pin edges capture, whatever the polarity bit.
- R8: Reading address 0 returns the capture register in modes 10 and 11 and the live count in modes 00 and 01.
- R9: Timer writes.
  - A write to address 0 always updates the reload latch.
  - While the timer is stopped, the same write also loads the counter.
- R10: Flags (address 2).
  - Bit 0 is the underflow flag and bit 1 is the pin-event flag.
  - The flags are sticky.
  - Writing 0 to a bit clears it and writing 1 leaves it unchanged.
  - If an event sets a flag in the same cycle as a clearing write, the set wins.
- R11: When a capture and an underflow fall in the same cycle, the capture wins: the counter loads the reload latch and the underflow flag is not set.
- R12: Stop bit.
  - While the stop bit is 1 the counter does not change, except through a timer write.
  - While the stop bit is 1 no capture happens.

Control register (address 1) fields:

| Bits | Field | Meaning |
|------|-------|---------|
| [1:0] | mode | 00 square wave, 01 event counting, 10 period, 11 pulse width |
| [2] | polarity | edge or start-level select, depending on mode |
| [4:3] | psel | prescaler select |
| [5] | stop | 1 halts counting |

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| pin_in | input | 1 | Synchronized pin level |
| pin_out | output | 1 | Pin drive level in square-wave mode |
| pin_oe | output | 1 | Pin output enable |
| irq_uf | output | 1 | Sticky underflow request flag |
| irq_evt | output | 1 | Sticky pin-event request flag |

## Verification
A wrong count or a lost count step shows up on bus_rdata at address 0 in the cycle after the step. In the measuring modes it shows up only at the next capture, in the captured value.

A wrong reload or a misplaced underflow moves the next edge of pin_out and the rise of irq_uf by at least one prescaled period. A capture on the wrong edge sets irq_evt half a pin period early or late. A capture that wrongly beats or loses to an underflow leaves irq_uf set when it should stay low.

The bench model compares every port on every clock, so each of these faults is reported in the cycle it first reaches a pin.

// File: rtl/cdt_pkg.sv
package cdt_pkg;

  typedef enum logic [1:0] {
    MD_SQUARE = 2'b00,
    MD_EVENT  = 2'b01,
    MD_PERIOD = 2'b10,
    MD_WIDTH  = 2'b11
  } cdt_mode_e;

  localparam logic [1:0] ADDR_TMR = 2'd0;
  localparam logic [1:0] ADDR_CTL = 2'd1;
  localparam logic [1:0] ADDR_FLG = 2'd2;

  // clocks per count step for a prescaler select code
  function automatic int unsigned presc_div(input logic [1:0] sel);
    return 32'd8 << sel;
  endfunction

  // pin edge that counts in event mode
  function automatic logic count_edge(input logic pol, input logic rise, input logic fall);
    return pol ? fall : rise;
  endfunction

  // pin edge that captures in the measuring modes
  function automatic logic capture_edge(input cdt_mode_e m, input logic pol,
                                        input logic rise, input logic fall);
    case (m)
      MD_PERIOD: return pol ? rise : fall;
      MD_WIDTH:  return rise | fall;
      default:   return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/cdt_prescaler.sv
module cdt_prescaler #(
  parameter int PRE_W = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sel,
  output logic       tick
);
  import cdt_pkg::*;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;

  assign mask = PRE_W'(presc_div(sel) - 1);
  assign tick = (pre_q & mask) == mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/cdt_edge.sv
module cdt_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_in,
  output logic rise,
  output logic fall
);
  logic pin_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= 1'b0;
    else        pin_q <= pin_in;
  end

  assign rise = pin_in & ~pin_q;
  assign fall = ~pin_in & pin_q;
endmodule

// File: rtl/cdt_counter.sv
module cdt_counter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          cap,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  input  logic [DW-1:0] reload,
  output logic [DW-1:0] cnt,
  output logic [DW-1:0] cap_val,
  output logic          uf
);
  // a capture takes precedence over an underflow in the same cycle
  assign uf = en && (cnt == '0) && !cap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '1;
      cap_val <= '0;
    end else if (cap) begin
      cap_val <= cnt;
      cnt     <= reload;
    end else if (uf) begin
      cnt <= reload;
    end else if (en) begin
      cnt <= cnt - 1'b1;
    end else if (load) begin
      cnt <= load_val;
    end
  end
endmodule

// File: rtl/capture_dtimer.sv
module capture_dtimer #(
  parameter int DW    = 8,
  parameter int PRE_W = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    bus_addr,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          pin_in,
  output logic          pin_out,
  output logic          pin_oe,
  output logic          irq_uf,
  output logic          irq_evt
);
  import cdt_pkg::*;

  cdt_mode_e     mode_q;
  logic          pol_q, stop_q;
  logic [1:0]    psel_q;
  logic [DW-1:0] reload_q, cnt_q, cap_q;
  logic          tmr_wr, ctl_wr, flg_wr;
  logic          tick, rise, fall;
  logic          cnt_en, cap_evt, uf_evt;

  assign tmr_wr = bus_wr && (bus_addr == ADDR_TMR);
  assign ctl_wr = bus_wr && (bus_addr == ADDR_CTL);
  assign flg_wr = bus_wr && (bus_addr == ADDR_FLG);

  cdt_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .sel(psel_q), .tick(tick));

  cdt_edge u_edge (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .rise(rise), .fall(fall));

  assign cnt_en  = !stop_q && ((mode_q == MD_EVENT) ? count_edge(pol_q, rise, fall) : tick);
  assign cap_evt = !stop_q && capture_edge(mode_q, pol_q, rise, fall);

  cdt_counter #(.DW(DW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(cnt_en), .cap(cap_evt),
    .load(tmr_wr && stop_q), .load_val(bus_wdata), .reload(reload_q),
    .cnt(cnt_q), .cap_val(cap_q), .uf(uf_evt));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= MD_SQUARE;
      pol_q    <= 1'b0;
      psel_q   <= 2'd0;
      stop_q   <= 1'b1;
      reload_q <= '1;
    end else begin
      if (tmr_wr) reload_q <= bus_wdata;
      if (ctl_wr) begin
        mode_q <= cdt_mode_e'(bus_wdata[1:0]);
        pol_q  <= bus_wdata[2];
        psel_q <= bus_wdata[4:3];
        stop_q <= bus_wdata[5];
      end
    end
  end

  // sticky flags: write 0 clears, a new event wins over the clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_uf  <= 1'b0;
      irq_evt <= 1'b0;
    end else begin
      irq_uf  <= (flg_wr ? (irq_uf  & bus_wdata[0]) : irq_uf)  | uf_evt;
      irq_evt <= (flg_wr ? (irq_evt & bus_wdata[1]) : irq_evt) | cap_evt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              pin_out <= 1'b1;
    else if (ctl_wr)                         pin_out <= ~bus_wdata[2];
    else if (uf_evt && mode_q == MD_SQUARE)  pin_out <= ~pin_out;
  end

  assign pin_oe = (mode_q == MD_SQUARE);

  always_comb begin
    case (bus_addr)
      ADDR_TMR: bus_rdata = (mode_q == MD_PERIOD || mode_q == MD_WIDTH) ? cap_q : cnt_q;
      ADDR_CTL: bus_rdata = DW'({stop_q, psel_q, pol_q, mode_q});
      ADDR_FLG: bus_rdata = DW'({irq_evt, irq_uf});
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/cdt_checker.sv
module cdt_checker #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          uf_evt,
  input logic          cap_evt,
  input logic [DW-1:0] cnt_q,
  input logic [DW-1:0] reload_q,
  input logic [DW-1:0] cap_q,
  input logic          irq_uf,
  input logic          irq_evt,
  input logic          pin_out,
  input logic [1:0]    mode,
  input logic          stop,
  input logic          tmr_wr,
  input logic          ctl_wr,
  input logic          flg_wr
);
  assert_uf_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
    uf_evt |=> (irq_uf && cnt_q == $past(reload_q)));

  assert_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> (irq_evt && cap_q == $past(cnt_q) && cnt_q == $past(reload_q)));

  assert_square_toggle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (uf_evt && mode == 2'b00 && !ctl_wr) |=> (pin_out != $past(pin_out)));

  assert_stop_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !tmr_wr) |=> $stable(cnt_q));

  assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_uf && !flg_wr) |=> irq_uf);
endmodule

bind capture_dtimer cdt_checker #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .uf_evt(uf_evt), .cap_evt(cap_evt),
  .cnt_q(cnt_q), .reload_q(reload_q), .cap_q(cap_q),
  .irq_uf(irq_uf), .irq_evt(irq_evt), .pin_out(pin_out),
  .mode(mode_q), .stop(stop_q), .tmr_wr(tmr_wr), .ctl_wr(ctl_wr), .flg_wr(flg_wr));

// File: tb/capture_dtimer_test.sv
module capture_dtimer_test;
  localparam int CLKP = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       pin_in = 1'b0;
  logic       pin_out, pin_oe, irq_uf, irq_evt;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLKP/2) clk = ~clk;

  capture_dtimer uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq_uf(irq_uf), .irq_evt(irq_evt));

  // ---------------- behavioural reference model ----------------
  int m_cnt, m_rel, m_cap, m_mode, m_psel, m_pre;
  bit m_pol, m_stop, m_uf, m_evt, m_out, m_prev;

  task automatic model_reset();
    m_cnt = 255; m_rel = 255; m_cap = 0; m_mode = 0; m_psel = 0; m_pre = 0;
    m_pol = 0; m_stop = 1; m_uf = 0; m_evt = 0; m_out = 1; m_prev = 0;
  endtask

  initial model_reset();

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else begin
      int  n;
      bit  tick, rise, fall, en, cap, uf;
      n    = 8 << m_psel;
      tick = (m_pre % n) == n - 1;
      m_pre = (m_pre + 1) % 64;
      rise = pin_in && !m_prev;
      fall = !pin_in && m_prev;
      m_prev = pin_in;
      if (m_mode == 1) en = !m_stop && (m_pol ? fall : rise);
      else             en = !m_stop && tick;
      cap = !m_stop && ((m_mode == 2 && (m_pol ? rise : fall)) || (m_mode == 3 && (rise || fall)));
      uf  = en && (m_cnt == 0) && !cap;
      if (cap) begin m_cap = m_cnt; m_cnt = m_rel; end
      else if (uf) m_cnt = m_rel;
      else if (en) m_cnt = m_cnt - 1;
      else if (bus_wr && bus_addr == 0 && m_stop) m_cnt = bus_wdata;
      if (bus_wr && bus_addr == 2) begin
        m_uf  = m_uf  & bus_wdata[0];
        m_evt = m_evt & bus_wdata[1];
      end
      m_uf  = m_uf | uf;
      m_evt = m_evt | cap;
      if (bus_wr && bus_addr == 1) m_out = !bus_wdata[2];
      else if (uf && m_mode == 0) m_out = !m_out;
      if (bus_wr && bus_addr == 0) m_rel = bus_wdata;
      if (bus_wr && bus_addr == 1) begin
        m_mode = bus_wdata[1:0]; m_pol = bus_wdata[2];
        m_psel = bus_wdata[4:3]; m_stop = bus_wdata[5];
      end
    end
  end

  task automatic check(input string req, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got=0x%0h expected=0x%0h at %0t", req, got, exp, $time);
    end
  endtask

  function automatic int model_rdata(input int a);
    case (a)
      0: return (m_mode >= 2) ? m_cap : m_cnt;
      1: return {m_stop, m_psel[1:0], m_pol, m_mode[1:0]};
      2: return {m_evt, m_uf};
      default: return 0;
    endcase
  endfunction

  // compare every port on every clock, a quarter period after the edge
  always begin
    @(posedge clk);
    #(CLKP/4);
    if (rst_n && !done) begin
      check(bus_addr == 0 ? "R8 rdata" : "R10 rdata", bus_rdata, model_rdata(bus_addr));
      check("R4 pin_out", pin_out, m_out);
      check("R4 pin_oe", pin_oe, m_mode == 0);
      check("R3 irq_uf", irq_uf, m_uf);
      check("R6 irq_evt", irq_evt, m_evt);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 2'd0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    @(negedge clk);
    bus_addr = a;
    #1 v = bus_rdata;
    @(negedge clk);
    bus_addr = 2'd0;
  endtask

  task automatic pulse(input int hi, input int lo);
    @(negedge clk); pin_in = 1'b1; idle(hi);
    pin_in = 1'b0; idle(lo);
  endtask

  initial begin
    #(CLKP*150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got=hang expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int v, v2, p0;
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(0, v); check("R1 count", v, 255);
    rd(1, v); check("R1 control", v, 8'h20);
    rd(2, v); check("R1 flags", v, 0);
    check("R1 pin_out", pin_out, 1);
    check("R1 pin_oe", pin_oe, 1);

    // R9 stopped write loads counter
    wr(0, 8'h03);
    rd(0, v); check("R9 stopped load", v, 3);

    // R4 square wave, period 4 steps * 8 clocks = 32 clocks
    wr(1, 8'h00);
    idle(50);
    p0 = pin_out;
    idle(32);
    check("R4 toggle in period", pin_out, !p0);
    check("R3 underflow flag", irq_uf, 1);
    wr(1, 8'h04);
    check("R4 start low pol1", pin_out, 0);
    idle(70);

    // R9 write while running: counter not loaded
    rd(0, v);
    wr(0, 8'h07);
    rd(0, v2);
    check("R9 running write keeps count", (v2 != 8'h07) || (v == 8'h00) || (v == 8'h01) || (v == 8'h02) || (v == 8'h03), 1);
    idle(100);

    // R10 flag clearing
    wr(2, 8'h03);
    check("R10 write 1 keeps", irq_uf, 1);
    wr(2, 8'h00);
    check("R10 write 0 clears", irq_uf, 0);

    // R2 prescaler /64
    wr(1, 8'h38);
    wr(0, 8'd200);
    wr(1, 8'h18);
    rd(0, v);
    idle(638);
    rd(0, v2);
    check("R2 divide by 64", v - v2, 10);

    // R5 event counting, rising edges
    wr(1, 8'h21);
    wr(0, 8'd5);
    wr(1, 8'h01);
    repeat (3) pulse(3, 3);
    rd(0, v); check("R5 rising edges counted", v, 2);
    // falling edges with polarity 1
    wr(1, 8'h25); wr(0, 8'd9); wr(1, 8'h05);
    pulse(3, 3); pulse(3, 3);
    rd(0, v); check("R5 falling edges counted", v, 7);

    // R6 period mode pol0: rising edge ignored
    wr(1, 8'h22); wr(0, 8'd200); wr(2, 8'h00); wr(1, 8'h02);
    @(negedge clk); pin_in = 1'b1; idle(5);
    check("R6 rising edge ignored", irq_evt, 0);
    pin_in = 1'b0; idle(3);
    check("R6 falling edge captures", irq_evt, 1);
    repeat (4) pulse(40, 40);
    rd(0, v); check("R8 capture readback", v, m_cap);

    // R7 pulse width, both edges
    wr(1, 8'h23); wr(2, 8'h00); wr(1, 8'h07);
    @(negedge clk); pin_in = 1'b1; idle(3);
    check("R7 rising edge captures", irq_evt, 1);
    wr(2, 8'h00);
    pin_in = 1'b0; idle(3);
    check("R7 falling edge captures", irq_evt, 1);
    repeat (4) pulse(40, 24);

    // R11 capture beats underflow: reload 0, pin toggles every clock
    wr(1, 8'h23); wr(0, 8'd0);
    @(negedge clk); pin_in = ~pin_in;
    wr(2, 8'h00);
    wr(1, 8'h03);
    repeat (40) begin @(negedge clk); pin_in = ~pin_in; end
    check("R11 no underflow on capture", irq_uf, 0);
    check("R11 capture flag", irq_evt, 1);

    // R12 stop halts counting and capture
    wr(1, 8'h23); wr(2, 8'h00);
    rd(1, v); check("R12 stop readback", v, 8'h23);
    repeat (3) pulse(4, 4);
    check("R12 no capture stopped", irq_evt, 0);
    rd(0, v); check("R12 capture held", v, m_cap);

    idle(5);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule